// File: doc/BRIEF.md
# Bus watch comparator pair

This block watches a processor's instruction bus and data bus and raises a request when a programmed condition appears. It holds two identical comparator units. Each unit stores an address, a data word and a small control word, each paired with a mask. Every cycle, each unit compares the bus it has been told to watch against those values and reports a hit. A unit turns its hit into a request only when it is enabled and its qualifiers are satisfied.

Debug logic uses the request to halt the core on an instruction fetch (breakpoint) or on a data access (watchpoint). Software programs the units through a simple write port with a 5-bit register address. The two units can be combined:

- With the same-cycle qualifier (range), unit 0 fires only while unit 1 also matches. This bounds an access between two conditions.
- With the sequence qualifier (chain), unit 0 fires only if unit 1 matched on the cycle before. This expresses "this access right after that one".

Unit 1 takes both qualifiers from top-level pins, so a further pair can be cascaded above it. All pins are plain levels. The block has no data stream, so it carries no valid/ready handshake and applies no back-pressure: it samples every cycle.

Top module: `wpt_pair`

## Requirements
- R1: Register writes decode as follows. Unit 0 uses addresses 0x08 to 0x0D and unit 1 uses 0x10 to 0x15. Within each unit, the offsets 0 to 5 select, in that order: address value, address mask, data value, data mask, control value, control mask. A write to any other address changes no register.
- R2: A mask bit of 1 excludes the matching address or data bit from the comparison. A mask bit of 0 requires that bit to equal the programmed value.
- R3: Control value bit 3 selects the bus that a unit compares. When it is 1, the unit compares d_addr, d_data and d_ctrl. When it is 0, it compares i_addr, i_data and i_ctrl.
- R4: Control value bits [2:0] are compared with the selected 3-bit control pins, under control mask bits [2:0]. The control pins are packed as follows. i_ctrl is {external condition, translated access, compressed-instruction state}. d_ctrl is {external condition, translated access, write}.
- R5: range_o[k] goes to 1 one clock after a cycle in which unit k's masked comparison matched, whatever the enable, chain and range bits hold.
- R6: req_o[k] goes to 1 one clock after a cycle in which unit k matched and control value bit 6 (enable) was 1 and its qualifiers held. Otherwise req_o[k] is 0.
- R7: For unit 1, control bit 4 (chain) requires chain_in to be 1 in the matching cycle. Control bit 5 (range) requires range_in to be 1 in that cycle. When both bits are set, both pins must be 1.
- R8: For unit 0, the range bit requires unit 1 to match in the same cycle. The chain bit requires unit 1 to have matched in the previous clock cycle.
- R9: With the data mask set to all ones, a unit matches on address and control alone, for any data value.
- R10: While rst_n is 0, req_o and range_o are 0. Reset clears every register, so both units leave reset disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| i_addr | input | 32 | Instruction bus address |
| i_data | input | 32 | Instruction bus data |
| i_ctrl | input | 3 | Instruction control {ext, translated, compressed} |
| d_addr | input | 32 | Data bus address |
| d_data | input | 32 | Data bus data |
| d_ctrl | input | 3 | Data control {ext, translated, write} |
| chain_in | input | 1 | Sequence qualifier for unit 1 |
| range_in | input | 1 | Same-cycle qualifier for unit 1 |
| req_o | output | 2 | Per-unit qualified request, registered |
| range_o | output | 2 | Per-unit raw match, registered |

## Verification
The bench programs a unit and then moves one address bit just outside a mask and just inside it. A design with an inverted mask sense would fire on the wrong one of the two. It selects the data side while the instruction bus still matches, which catches a unit that ignores bit 3. It also writes all ones to unused addresses next to each unit's window; a loose decoder would clobber a mask or a control value and change the next result. For the pair, it exercises the chain bit with a matching access from unit 1 one cycle early, then with the same access one cycle stale. A design that confuses the sequence qualifier with the same-cycle qualifier would fire on the stale case or miss the armed one.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int CMP_W      = 3;
  localparam int SIDE_BIT   = 3;
  localparam int CHAIN_BIT  = 4;
  localparam int RANGE_BIT  = 5;
  localparam int EN_BIT     = 6;
  localparam int CTRL_REG_W = 7;
  localparam int NUM_REGS   = 6;

  typedef enum logic [2:0] {
    OFF_ADDR_VAL = 3'd0,
    OFF_ADDR_MSK = 3'd1,
    OFF_DATA_VAL = 3'd2,
    OFF_DATA_MSK = 3'd3,
    OFF_CTRL_VAL = 3'd4,
    OFF_CTRL_MSK = 3'd5
  } reg_off_e;
endpackage

// File: rtl/wpt_match.sv
module wpt_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] obs,
  input  logic [W-1:0] val,
  input  logic [W-1:0] msk,
  output logic         eq
);
  assign eq = (((obs ^ val) & ~msk) == '0);
endmodule

// File: rtl/wpt_regfile.sv
module wpt_regfile
  import wpt_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RAW  = 5,
  parameter int WW   = 32,
  parameter int BASE = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RAW-1:0]        wr_addr,
  input  logic [WW-1:0]         wr_data,
  output logic [AW-1:0]         addr_val,
  output logic [AW-1:0]         addr_msk,
  output logic [DW-1:0]         data_val,
  output logic [DW-1:0]         data_msk,
  output logic [CTRL_REG_W-1:0] ctrl_val,
  output logic [CMP_W-1:0]      ctrl_msk
);
  localparam logic [RAW-1:0] BASE_V = BASE[RAW-1:0];
  localparam logic [RAW-1:0] NREG_V = NUM_REGS[RAW-1:0];

  logic [RAW-1:0] rel;
  logic           own;
  logic           unused_hi;

  assign rel       = wr_addr - BASE_V;
  assign own       = wr_en && (wr_addr >= BASE_V) && (rel < NREG_V);
  assign unused_hi = ^wr_data[WW-1:CTRL_REG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_val <= '0;
      addr_msk <= '0;
      data_val <= '0;
      data_msk <= '0;
      ctrl_val <= '0;
      ctrl_msk <= '0;
    end else if (own) begin
      case (reg_off_e'(rel[2:0]))
        OFF_ADDR_VAL: addr_val <= wr_data[AW-1:0];
        OFF_ADDR_MSK: addr_msk <= wr_data[AW-1:0];
        OFF_DATA_VAL: data_val <= wr_data[DW-1:0];
        OFF_DATA_MSK: data_msk <= wr_data[DW-1:0];
        OFF_CTRL_VAL: ctrl_val <= wr_data[CTRL_REG_W-1:0];
        OFF_CTRL_MSK: ctrl_msk <= wr_data[CMP_W-1:0];
        default: ;
      endcase
    end
  end

  // R1
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !own) |=> $stable({addr_val, addr_msk, data_val, data_msk, ctrl_val, ctrl_msk}));
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RAW  = 5,
  parameter int WW   = 32,
  parameter int BASE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RAW-1:0]   wr_addr,
  input  logic [WW-1:0]    wr_data,
  input  logic [AW-1:0]    i_addr,
  input  logic [DW-1:0]    i_data,
  input  logic [CMP_W-1:0] i_ctrl,
  input  logic [AW-1:0]    d_addr,
  input  logic [DW-1:0]    d_data,
  input  logic [CMP_W-1:0] d_ctrl,
  input  logic             chn_ok,
  input  logic             rng_ok,
  output logic             hit,
  output logic             req_q,
  output logic             rng_q
);
  logic [AW-1:0]         av, am, sel_addr;
  logic [DW-1:0]         dv, dm, sel_data;
  logic [CTRL_REG_W-1:0] cv;
  logic [CMP_W-1:0]      cm, sel_ctrl;
  logic                  a_eq, d_eq, c_eq, qual;

  wpt_regfile #(.AW(AW), .DW(DW), .RAW(RAW), .WW(WW), .BASE(BASE)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_val(av), .addr_msk(am), .data_val(dv), .data_msk(dm),
    .ctrl_val(cv), .ctrl_msk(cm)
  );

  always_comb begin
    if (cv[SIDE_BIT]) begin
      sel_addr = d_addr;
      sel_data = d_data;
      sel_ctrl = d_ctrl;
    end else begin
      sel_addr = i_addr;
      sel_data = i_data;
      sel_ctrl = i_ctrl;
    end
  end

  wpt_match #(.W(AW))    addr_cmp_i (.obs(sel_addr), .val(av), .msk(am), .eq(a_eq));
  wpt_match #(.W(DW))    data_cmp_i (.obs(sel_data), .val(dv), .msk(dm), .eq(d_eq));
  wpt_match #(.W(CMP_W)) ctrl_cmp_i (.obs(sel_ctrl), .val(cv[CMP_W-1:0]), .msk(cm), .eq(c_eq));

  assign hit  = a_eq && d_eq && c_eq;
  assign qual = cv[EN_BIT] && (!cv[CHAIN_BIT] || chn_ok) && (!cv[RANGE_BIT] || rng_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rng_q <= 1'b0;
    end else begin
      req_q <= hit && qual;
      rng_q <= hit;
    end
  end

  // R6
  req_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> rng_q);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cv[EN_BIT] |=> !req_q);
  // R7
  chain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cv[CHAIN_BIT] && !chn_ok) |=> !req_q);
  // R7
  range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cv[RANGE_BIT] && !rng_ok) |=> !req_q);
endmodule

// File: rtl/wpt_pair.sv
module wpt_pair #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int RAW      = 5,
  parameter int WW       = 32,
  parameter int NUNITS   = 2,
  parameter int U0_BASE  = 8,
  parameter int U1_BASE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [WW-1:0]     wr_data,
  input  logic [AW-1:0]     i_addr,
  input  logic [DW-1:0]     i_data,
  input  logic [2:0]        i_ctrl,
  input  logic [AW-1:0]     d_addr,
  input  logic [DW-1:0]     d_data,
  input  logic [2:0]        d_ctrl,
  input  logic              chain_in,
  input  logic              range_in,
  output logic [NUNITS-1:0] req_o,
  output logic [NUNITS-1:0] range_o
);
  logic [NUNITS-1:0] hit_vec, chn_vec, rng_vec;
  logic              h1_q;
  logic              unused_hit0;

  assign unused_hit0 = hit_vec[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h1_q <= 1'b0;
    else        h1_q <= hit_vec[1];
  end

  for (genvar k = 0; k < NUNITS; k++) begin : g_unit
    localparam int UBASE = (k == 0) ? U0_BASE : U1_BASE;
    if (k == 0) begin : g_lead
      assign chn_vec[k] = h1_q;
      assign rng_vec[k] = hit_vec[1];
    end else begin : g_tail
      assign chn_vec[k] = chain_in;
      assign rng_vec[k] = range_in;
    end
    wpt_unit #(.AW(AW), .DW(DW), .RAW(RAW), .WW(WW), .BASE(UBASE)) unit_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .i_addr(i_addr), .i_data(i_data), .i_ctrl(i_ctrl),
      .d_addr(d_addr), .d_data(d_data), .d_ctrl(d_ctrl),
      .chn_ok(chn_vec[k]), .rng_ok(rng_vec[k]),
      .hit(hit_vec[k]), .req_q(req_o[k]), .rng_q(range_o[k])
    );
  end

  // R8
  lead_chain_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o[0] && !range_o[1]) |-> range_o[0]);
endmodule

// File: tb/wpt_pair_tb_top.sv
module wpt_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] i_addr = '0, i_data = '0, d_addr = '0, d_data = '0;
  logic [2:0]  i_ctrl = '0, d_ctrl = '0;
  logic        chain_in = 1'b0, range_in = 1'b0;
  logic [1:0]  req_o, range_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_av[2], m_am[2], m_dv[2], m_dm[2], m_cv[2], m_cm[2];
  logic        prev_h1 = 1'b0;
  logic [3:0]  exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  wpt_pair dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .i_addr(i_addr), .i_data(i_data), .i_ctrl(i_ctrl),
    .d_addr(d_addr), .d_data(d_data), .d_ctrl(d_ctrl),
    .chain_in(chain_in), .range_in(range_in), .req_o(req_o), .range_o(range_o)
  );

  function automatic logic mhit(input int k);
    logic [31:0] a, d;
    logic [2:0]  c;
    a = m_cv[k][3] ? d_addr : i_addr;
    d = m_cv[k][3] ? d_data : i_data;
    c = m_cv[k][3] ? d_ctrl : i_ctrl;
    return (((a ^ m_av[k]) & ~m_am[k]) == 0) && (((d ^ m_dv[k]) & ~m_dm[k]) == 0) &&
           (((c ^ m_cv[k][2:0]) & ~m_cm[k][2:0]) == 0);
  endfunction

  function automatic logic mreq(input int k);
    logic cq, rq;
    cq = (k == 0) ? prev_h1 : chain_in;
    rq = (k == 0) ? mhit(1) : range_in;
    return m_cv[k][6] && mhit(k) && (!m_cv[k][4] || cq) && (!m_cv[k][5] || rq);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    prev_h1 = mhit(1);
    for (int k = 0; k < 2; k++) begin
      int base = (k == 0) ? 8 : 16;
      if (a >= base && a < base + 6) begin
        case (a - base)
          0: m_av[k] = v;
          1: m_am[k] = v;
          2: m_dv[k] = v;
          3: m_dm[k] = v;
          4: m_cv[k] = v;
          default: m_cm[k] = v;
        endcase
      end
    end
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [31:0] ia, input logic [31:0] id, input logic [2:0] ic,
                       input logic [31:0] da, input logic [31:0] dd, input logic [2:0] dc,
                       input logic ch, input logic rg, input string tag);
    i_addr = ia; i_data = id; i_ctrl = ic;
    d_addr = da; d_data = dd; d_ctrl = dc;
    chain_in = ch; range_in = rg;
    exp_q.push_back({mreq(1), mreq(0), mhit(1), mhit(0)});
    tag_q.push_back(tag);
    prev_h1 = mhit(1);
    @(posedge clk); @(negedge clk);
  endtask

  // scoreboard monitor
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({req_o, range_o} !== e) begin
        fails++;
        $display("FAIL %s: {req_o,range_o} actual %b expected %b", t, {req_o, range_o}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [31:0] EN = 32'h40, CHN = 32'h10, RNG = 32'h20, SIDE = 32'h08;
  localparam logic [31:0] OP = 32'hE3A0_0000;

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_av[k] = '0; m_am[k] = '0; m_dv[k] = '0; m_dm[k] = '0; m_cv[k] = '0; m_cm[k] = '0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if ({req_o, range_o} !== 4'b0) begin
      fails++;
      $display("FAIL R10 reset: actual %b expected 0000", {req_o, range_o});
    end
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R10 R5 idle after reset");
    // unit 0, instruction side
    wr(5'h08, 32'h1000); wr(5'h09, 0); wr(5'h0A, OP); wr(5'h0B, 0);
    wr(5'h0C, EN); wr(5'h0D, 32'h7);
    drive(32'h1000, OP, 0, 0, 0, 0, 0, 0, "R6 R3 instruction hit");
    drive(32'h1004, OP, 0, 0, 0, 0, 0, 0, "R2 unmasked address bit");
    wr(5'h09, 32'hF);
    drive(32'h1004, OP, 0, 0, 0, 0, 0, 0, "R2 masked address bit");
    drive(32'h1010, OP, 0, 0, 0, 0, 0, 0, "R2 bit beside mask");
    // data side
    wr(5'h0C, EN | SIDE);
    drive(32'h1000, OP, 0, 32'h9000, 0, 0, 0, 0, "R3 data side ignores instruction bus");
    drive(0, 0, 0, 32'h1008, OP, 0, 0, 0, "R3 data side hit");
    // control compare on write bit
    wr(5'h0D, 32'h6); wr(5'h0C, EN | SIDE | 32'h1);
    drive(0, 0, 0, 32'h1008, OP, 3'b001, 0, 0, "R4 write matches");
    drive(0, 0, 0, 32'h1008, OP, 3'b000, 0, 0, "R4 read mismatches");
    drive(0, 0, 0, 32'h1008, OP, 3'b111, 0, 0, "R4 masked control bits");
    // range without enable
    wr(5'h0C, SIDE | 32'h1);
    drive(0, 0, 0, 32'h1008, OP, 3'b001, 0, 0, "R5 range without enable");
    // address only
    wr(5'h0C, EN | SIDE); wr(5'h0D, 32'h7); wr(5'h0B, 32'hFFFF_FFFF);
    drive(0, 0, 0, 32'h1000, 32'h1234_5678, 0, 0, 0, "R9 data ignored");
    // unused addresses
    wr(5'h0E, 32'hFFFF_FFFF); wr(5'h07, 32'hFFFF_FFFF);
    wr(5'h16, 32'hFFFF_FFFF); wr(5'h1F, 32'hFFFF_FFFF);
    drive(0, 0, 0, 32'h2000, 0, 0, 0, 0, "R1 unused writes keep miss");
    drive(0, 0, 0, 32'h1000, 0, 0, 0, 0, "R1 unused writes keep hit");
    // unit 1 with pin qualifiers
    wr(5'h10, 32'h3000); wr(5'h11, 0); wr(5'h12, 0); wr(5'h13, 32'hFFFF_FFFF);
    wr(5'h15, 32'h7); wr(5'h14, EN | CHN);
    drive(32'h3000, 0, 0, 0, 0, 0, 0, 0, "R7 chain_in low");
    drive(32'h3000, 0, 0, 0, 0, 0, 1, 0, "R7 chain_in high");
    wr(5'h14, EN | RNG);
    drive(32'h3000, 0, 0, 0, 0, 0, 0, 0, "R7 range_in low");
    drive(32'h3000, 0, 0, 0, 0, 0, 0, 1, "R7 range_in high");
    wr(5'h14, EN | RNG | CHN);
    drive(32'h3000, 0, 0, 0, 0, 0, 1, 0, "R7 both set, range_in low");
    // unit 0 paired with unit 1
    wr(5'h14, EN); wr(5'h0C, EN | SIDE | RNG);
    drive(32'h3000, 0, 0, 32'h1000, 0, 0, 0, 0, "R8 range pair both hit");
    drive(32'h3004, 0, 0, 32'h1000, 0, 0, 0, 0, "R8 range pair unit1 miss");
    wr(5'h0C, EN | SIDE | CHN);
    drive(32'h3000, 0, 0, 32'h5000, 0, 0, 0, 0, "R8 chain arm");
    drive(0, 0, 0, 32'h1000, 0, 0, 0, 0, "R8 chain after arm");
    drive(0, 0, 0, 32'h1000, 0, 0, 0, 0, "R8 chain stale");
    drive(32'h3000, 0, 0, 32'h1000, 0, 0, 0, 0, "R8 chain same cycle only");
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule